// File: doc/BRIEF.md
# Two-way write-back data cache

This block is a set-associative data cache with two ways, placed between a load/store unit and a line-granular memory port. It allocates on both read and write misses and keeps modified lines until they are evicted. With the default parameters it holds 64 sets of 64-byte lines in each way, for 8 KB of data. The CPU side issues one access at a time with a valid/ready handshake. An access moves 1, 2, 4, 8 or 16 bytes. The memory side moves whole lines with a request/acknowledge handshake.

A hit completes in the cycle it is presented. On a miss the cache chooses a victim way from two per-line "filled-earlier" flags. If the victim is modified, it is first written back. The cache then refills the line and finishes the access from the refilled line. The requester must hold its request fields steady while valid is high and ready is low.

Top module: `dcache2w`

## Requirements
- R1: An address splits into a byte offset (bits 5..0), a set index (bits 11..6) and a tag (bits 31..12). A way hits only if its line is valid and its stored tag equals the access tag. Way 0 is looked at before way 1, and at most one way ever hits.
- R2: A valid access that hits raises cpu_ready in the same cycle it is presented. That cycle completes the access and, for a read, carries its data on cpu_rdata.
- R3: cpu_size codes 0,1,2,3,4 mean 1,2,4,8,16 bytes. The access starts at the byte offset rounded down to a multiple of its size. cpu_rdata bits [8n-1:0] carry those n bytes, lowest address in bits 7..0, and all higher bits are zero.
- R4: A write stores the low n bytes of cpu_wdata at the rounded-down offset. Every other byte of the line keeps its value.
- R5: On a miss, the victim way is the XOR of the two ways' filled-earlier flags in that set. After reset the first fill of a set goes to way 0. The following fills of that set alternate between the ways.
- R6: If the victim line is both valid and modified, the cache first issues a memory write (mem_we=1). The write carries the whole line at address {old tag, set, 6'b0}, and the refill is issued after it is acknowledged. A victim that is clean or invalid is never written back.
- R7: A refill is a memory read (mem_we=0) at the line-aligned access address. It installs the line as valid and unmodified and toggles its filled-earlier flag. The stalled access completes in the cycle after the refill acknowledge.
- R8: Every write, whether it hit or missed, marks its line as modified. Reads never do.
- R9: While a memory transfer is outstanding, cpu_ready stays low. mem_req, mem_addr and mem_we then stay unchanged until mem_ack.
- R10: Reset leaves every line invalid and every flag clear. After reset, cpu_ready and mem_req are low until the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Access request present |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_size | input | 3 | Size code, 2^code bytes |
| cpu_wdata | input | 8*CPU_BYTES | Store data, right-justified |
| cpu_rdata | output | 8*CPU_BYTES | Load data, right-justified, zero above size |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 8*LINE_BYTES | Line being written back |
| mem_ack | input | 1 | Transfer done; refill data valid |
| mem_rdata | input | 8*LINE_BYTES | Refill line |

## Verification
A hit is due in the same cycle its valid is first seen. A missed access is due exactly one cycle after the refill acknowledge. A write-back always comes before its refill, one acknowledge apart. The bench presents inputs just after a rising edge and judges every handshake on the falling edge. For each access it queues the memory transfers and the response it expects, in order. A monitor then takes them off the queue as they appear and compares the cycle number as well as the address and data. As a result, an extra, missing or late transfer or response shows up as a mismatch.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_FILL   = 2'd2
  } dc_state_e;

  typedef enum logic [1:0] {
    TOP_SET_DIRTY = 2'd0,
    TOP_CLEAN     = 2'd1,
    TOP_INSTALL   = 2'd2
  } tag_op_e;

  // victim way from the two filled-earlier flags of a set
  function automatic logic pick_victim(input logic flag0, input logic flag1);
    return flag0 ^ flag1;
  endfunction

  // priority select: way 0 wins over way 1
  function automatic logic pick_hit_way(input logic [1:0] hits);
    return ~hits[0];
  endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SET_W-1:0]     lk_set,
  input  logic [TAG_W-1:0]     lk_tag,
  output logic [1:0]           hit_vec,
  output logic [1:0][TAG_W-1:0] way_tag,
  output logic [1:0]           way_valid,
  output logic [1:0]           way_dirty,
  output logic [1:0]           way_lrf,
  input  logic                 upd_en,
  input  logic [SET_W-1:0]     upd_set,
  input  logic                 upd_way,
  input  dc_pkg::tag_op_e      upd_op,
  input  logic [TAG_W-1:0]     upd_tag
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [SETS-1:0]  lrf_q;
    logic             sel;

    assign sel = upd_en && (upd_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
        lrf_q   <= '0;
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
      end else if (sel) begin
        case (upd_op)
          dc_pkg::TOP_SET_DIRTY: dirty_q[upd_set] <= 1'b1;
          dc_pkg::TOP_CLEAN:     dirty_q[upd_set] <= 1'b0;
          dc_pkg::TOP_INSTALL: begin
            tag_q[upd_set]   <= upd_tag;
            valid_q[upd_set] <= 1'b1;
            dirty_q[upd_set] <= 1'b0;
            lrf_q[upd_set]   <= ~lrf_q[upd_set];
          end
          default: ;
        endcase
      end
    end

    assign way_tag[w]   = tag_q[lk_set];
    assign way_valid[w] = valid_q[lk_set];
    assign way_dirty[w] = dirty_q[lk_set];
    assign way_lrf[w]   = lrf_q[lk_set];
    assign hit_vec[w]   = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  localparam int SET_W   = $clog2(SETS),
  localparam int IDX_W   = SET_W + 1,
  localparam int ENTRIES = 2 * SETS,
  localparam int LINE_W  = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [LINE_W-1:0]     rd_line,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [LINE_BYTES-1:0] wr_be,
  input  logic [LINE_W-1:0]     wr_line
);

  logic [LINE_W-1:0] line_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) line_q[e] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (wr_be[b]) line_q[wr_idx][8*b +: 8] <= wr_line[8*b +: 8];
      end
    end
  end

  assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/dc_lane.sv
module dc_lane #(
  parameter int LINE_BYTES = 64,
  parameter int CPU_BYTES  = 16,
  localparam int OFF_W    = $clog2(LINE_BYTES),
  localparam int LINE_W   = 8 * LINE_BYTES,
  localparam int CPU_W    = 8 * CPU_BYTES,
  localparam int SIZE_MAX = $clog2(CPU_BYTES)
) (
  input  logic [OFF_W-1:0]      addr_off,
  input  logic [2:0]            size_code,
  input  logic [CPU_W-1:0]      wdata,
  input  logic [LINE_W-1:0]     line_in,
  output logic [LINE_BYTES-1:0] be,
  output logic [LINE_W-1:0]     line_wr,
  output logic [CPU_W-1:0]      rdata
);

  // number of bytes moved by a size code (codes above the maximum clamp)
  function automatic logic [OFF_W:0] bytes_of(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'(SIZE_MAX)) ? 3'(SIZE_MAX) : code;
    return (OFF_W+1)'(1) << c;
  endfunction

  // offset rounded down to the access size
  function automatic logic [OFF_W-1:0] align_off(input logic [OFF_W-1:0] off,
                                                  input logic [OFF_W:0]   nb);
    logic [OFF_W:0] m;
    m = nb - (OFF_W+1)'(1);
    return off & ~m[OFF_W-1:0];
  endfunction

  logic [OFF_W:0]   nbytes;
  logic [OFF_W-1:0] eff_off;
  logic [OFF_W:0]   lo_b;
  logic [OFF_W:0]   hi_b;
  logic [LINE_W-1:0] shifted;
  logic [CPU_W-1:0]  rd_raw;

  assign nbytes  = bytes_of(size_code);
  assign eff_off = align_off(addr_off, nbytes);
  assign lo_b    = {1'b0, eff_off};
  assign hi_b    = lo_b + nbytes;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_be
    assign be[b] = ((OFF_W+1)'(b) >= lo_b) && ((OFF_W+1)'(b) < hi_b);
  end

  assign line_wr = {{(LINE_W-CPU_W){1'b0}}, wdata} << {eff_off, 3'b000};
  assign shifted = line_in >> {eff_off, 3'b000};
  assign rd_raw  = shifted[CPU_W-1:0];

  for (genvar i = 0; i < CPU_BYTES; i++) begin : g_rd
    assign rdata[8*i +: 8] = ((OFF_W+1)'(i) < nbytes) ? rd_raw[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int TAG_W  = 20,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  input  logic               lk_hit,
  input  logic               vic_way,
  input  logic               vic_wb,
  input  logic [TAG_W-1:0]   vic_tag,
  input  logic [LADDR_W-1:0] line_addr,
  input  logic               mem_ack,
  output dc_pkg::dc_state_e  state,
  output logic               miss_start,
  output logic               wb_done,
  output logic               fill_done,
  output logic               vic_way_q,
  output logic [TAG_W-1:0]   vic_tag_q,
  output logic [LADDR_W-1:0] miss_line_q
);
  import dc_pkg::*;

  dc_state_e state_q;

  assign state      = state_q;
  assign miss_start = (state_q == ST_LOOKUP) && cpu_valid && !lk_hit;
  assign wb_done    = (state_q == ST_WBACK) && mem_ack;
  assign fill_done  = (state_q == ST_FILL) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_LOOKUP;
      vic_way_q   <= 1'b0;
      vic_tag_q   <= '0;
      miss_line_q <= '0;
    end else begin
      case (state_q)
        ST_LOOKUP: begin
          if (miss_start) begin
            vic_way_q   <= vic_way;
            vic_tag_q   <= vic_tag;
            miss_line_q <= line_addr;
            state_q     <= vic_wb ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (wb_done)   state_q <= ST_FILL;
        ST_FILL:  if (fill_done) state_q <= ST_LOOKUP;
        default:  state_q <= ST_LOOKUP;
      endcase
    end
  end

endmodule

// File: rtl/dcache2w.sv
module dcache2w #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int CPU_BYTES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic                    cpu_write,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [2:0]              cpu_size,
  input  logic [8*CPU_BYTES-1:0]  cpu_wdata,
  output logic [8*CPU_BYTES-1:0]  cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*LINE_BYTES-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [8*LINE_BYTES-1:0] mem_rdata
);
  import dc_pkg::*;

  localparam int SET_W   = $clog2(SETS);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W;
  localparam int IDX_W   = SET_W + 1;
  localparam int LINE_W  = 8 * LINE_BYTES;
  localparam int LADDR_W = ADDR_W - OFF_W;

  // address fields of the presented access
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [OFF_W-1:0] lk_off;
  assign lk_off = cpu_addr[OFF_W-1:0];
  assign lk_set = cpu_addr[OFF_W +: SET_W];
  assign lk_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // tag lookup
  logic [1:0]            hit_vec;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [1:0]            way_valid;
  logic [1:0]            way_dirty;
  logic [1:0]            way_lrf;
  logic                  tag_upd_en;
  logic [SET_W-1:0]      tag_upd_set;
  logic                  tag_upd_way;
  tag_op_e               tag_upd_op;
  logic [TAG_W-1:0]      tag_upd_tag;

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .hit_vec  (hit_vec),
    .way_tag  (way_tag),
    .way_valid(way_valid),
    .way_dirty(way_dirty),
    .way_lrf  (way_lrf),
    .upd_en   (tag_upd_en),
    .upd_set  (tag_upd_set),
    .upd_way  (tag_upd_way),
    .upd_op   (tag_upd_op),
    .upd_tag  (tag_upd_tag)
  );

  // named internal events
  logic lk_hit;
  logic hit_way;
  logic vic_way;
  logic vic_wb;
  assign lk_hit  = |hit_vec;
  assign hit_way = pick_hit_way(hit_vec);
  assign vic_way = pick_victim(way_lrf[0], way_lrf[1]);
  assign vic_wb  = way_valid[vic_way] && way_dirty[vic_way];

  // miss sequencing
  dc_state_e          state;
  logic               miss_start;
  logic               wb_done;
  logic               fill_done;
  logic               vic_way_q;
  logic [TAG_W-1:0]   vic_tag_q;
  logic [LADDR_W-1:0] miss_line_q;

  dc_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .lk_hit     (lk_hit),
    .vic_way    (vic_way),
    .vic_wb     (vic_wb),
    .vic_tag    (way_tag[vic_way]),
    .line_addr  (cpu_addr[ADDR_W-1:OFF_W]),
    .mem_ack    (mem_ack),
    .state      (state),
    .miss_start (miss_start),
    .wb_done    (wb_done),
    .fill_done  (fill_done),
    .vic_way_q  (vic_way_q),
    .vic_tag_q  (vic_tag_q),
    .miss_line_q(miss_line_q)
  );

  logic [SET_W-1:0] miss_set;
  logic [TAG_W-1:0] miss_tag;
  assign miss_set = miss_line_q[SET_W-1:0];
  assign miss_tag = miss_line_q[SET_W +: TAG_W];

  logic cpu_fire;
  assign cpu_ready = (state == ST_LOOKUP) && lk_hit;
  assign cpu_fire  = cpu_valid && cpu_ready;

  // data array
  logic [IDX_W-1:0]      dat_rd_idx;
  logic [LINE_W-1:0]     dat_rd_line;
  logic                  dat_wr_en;
  logic [IDX_W-1:0]      dat_wr_idx;
  logic [LINE_BYTES-1:0] dat_wr_be;
  logic [LINE_W-1:0]     dat_wr_line;

  assign dat_rd_idx = (state == ST_WBACK) ? {miss_set, vic_way_q} : {lk_set, hit_way};

  dc_data_store #(.SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (dat_rd_idx),
    .rd_line(dat_rd_line),
    .wr_en  (dat_wr_en),
    .wr_idx (dat_wr_idx),
    .wr_be  (dat_wr_be),
    .wr_line(dat_wr_line)
  );

  // byte lanes of the access
  logic [LINE_BYTES-1:0] lane_be;
  logic [LINE_W-1:0]     lane_line;

  dc_lane #(.LINE_BYTES(LINE_BYTES), .CPU_BYTES(CPU_BYTES)) u_lane (
    .addr_off (lk_off),
    .size_code(cpu_size),
    .wdata    (cpu_wdata),
    .line_in  (dat_rd_line),
    .be       (lane_be),
    .line_wr  (lane_line),
    .rdata    (cpu_rdata)
  );

  // update arbitration: refill, write-back clean, store hit are exclusive
  always_comb begin
    dat_wr_en   = 1'b0;
    dat_wr_idx  = {lk_set, hit_way};
    dat_wr_be   = lane_be;
    dat_wr_line = lane_line;
    tag_upd_en  = 1'b0;
    tag_upd_set = lk_set;
    tag_upd_way = hit_way;
    tag_upd_op  = TOP_SET_DIRTY;
    tag_upd_tag = lk_tag;
    if (fill_done) begin
      dat_wr_en   = 1'b1;
      dat_wr_idx  = {miss_set, vic_way_q};
      dat_wr_be   = '1;
      dat_wr_line = mem_rdata;
      tag_upd_en  = 1'b1;
      tag_upd_set = miss_set;
      tag_upd_way = vic_way_q;
      tag_upd_op  = TOP_INSTALL;
      tag_upd_tag = miss_tag;
    end else if (wb_done) begin
      tag_upd_en  = 1'b1;
      tag_upd_set = miss_set;
      tag_upd_way = vic_way_q;
      tag_upd_op  = TOP_CLEAN;
    end else if (cpu_fire && cpu_write) begin
      dat_wr_en   = 1'b1;
      tag_upd_en  = 1'b1;
    end
  end

  // memory port
  assign mem_req   = (state != ST_LOOKUP);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? {vic_tag_q, miss_set, {OFF_W{1'b0}}}
                                         : {miss_line_q, {OFF_W{1'b0}}};
  assign mem_wdata = dat_rd_line;

endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        hit_vec,
  input logic              miss_start,
  input logic              wb_done,
  input logic              fill_done
);

  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);

  assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_line_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  assert_fill_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> (mem_req && !mem_we));

  assert_done_after_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && cpu_valid) |=> cpu_ready);

  assert_miss_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |=> mem_req);

endmodule

bind dcache2w dc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .hit_vec   (hit_vec),
  .miss_start(miss_start),
  .wb_done   (wb_done),
  .fill_done (fill_done)
);

// File: tb/test_dcache2w.sv
module test_dcache2w;
  localparam int LINE_W = 512;
  localparam int CPU_W  = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              cpu_valid;
  logic              cpu_ready;
  logic              cpu_write;
  logic [31:0]       cpu_addr;
  logic [2:0]        cpu_size;
  logic [CPU_W-1:0]  cpu_wdata;
  logic [CPU_W-1:0]  cpu_rdata;
  logic              mem_req;
  logic              mem_we;
  logic [31:0]       mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic              mem_ack;
  logic [LINE_W-1:0] mem_rdata;

  dcache2w i_dcache2w (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // views of memory: what the CPU has stored, and what memory holds
  logic [7:0] cpu_view [logic [31:0]];
  logic [7:0] mem_view [logic [31:0]];

  function automatic logic [7:0] init_byte(input logic [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'hA5;
  endfunction
  function automatic logic [7:0] cpu_byte(input logic [31:0] a);
    if (cpu_view.exists(a)) return cpu_view[a];
    return init_byte(a);
  endfunction
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    if (mem_view.exists(a)) return mem_view[a];
    return init_byte(a);
  endfunction

  // scoreboard items
  typedef enum int {K_WB, K_FILL, K_RESP} kind_e;
  typedef struct {
    kind_e             kind;
    logic [31:0]       addr;
    logic [LINE_W-1:0] line;
    logic [CPU_W-1:0]  rdata;
    bit                is_write;
    bit                miss;
  } item_t;
  item_t sbq [$];

  // bench-side picture of the tags
  logic [19:0] m_tag [2][64];
  bit          m_v   [2][64];
  bit          m_d   [2][64];
  bit          m_l   [2][64];

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 64; s++) begin
        m_tag[w][s] = '0; m_v[w][s] = 0; m_d[w][s] = 0; m_l[w][s] = 0;
      end
  end

  // driver: predicts, queues expectations, then drives the access
  task automatic access(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                        input logic [CPU_W-1:0] wd);
    int          set  = int'(a[11:6]);
    logic [19:0] t    = a[31:12];
    int          n    = 1 << sz;
    int          off  = int'(a[5:0]) & ~(n - 1);
    logic [31:0] base = {a[31:6], 6'b0};
    int          way;
    item_t       it;
    if (m_v[0][set] && m_tag[0][set] == t)      way = 0;
    else if (m_v[1][set] && m_tag[1][set] == t) way = 1;
    else                                        way = -1;
    it.miss = (way < 0);
    it.line = '0;
    it.rdata = '0;
    it.is_write = wr;
    if (it.miss) begin
      way = int'(m_l[0][set] ^ m_l[1][set]);
      if (m_v[way][set] && m_d[way][set]) begin
        it.kind = K_WB;
        it.addr = {m_tag[way][set], 6'(set), 6'b0};
        for (int b = 0; b < 64; b++) it.line[8*b +: 8] = cpu_byte(it.addr + 32'(b));
        sbq.push_back(it);
      end
      it.kind = K_FILL;
      it.addr = base;
      it.line = '0;
      sbq.push_back(it);
      m_tag[way][set] = t;
      m_v[way][set]   = 1;
      m_d[way][set]   = 0;
      m_l[way][set]   = ~m_l[way][set];
    end
    for (int i = 0; i < n; i++) it.rdata[8*i +: 8] = cpu_byte(base + 32'(off + i));
    if (wr) begin
      m_d[way][set] = 1;
      for (int i = 0; i < n; i++) cpu_view[base + 32'(off + i)] = wd[8*i +: 8];
    end
    it.kind = K_RESP;
    it.addr = a;
    sbq.push_back(it);
    @(posedge clk); #2;
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #2;
    cpu_valid = 1'b0;
  endtask

  // memory responder: acknowledges each request after two waiting cycles
  int wait_cnt = 0;
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk); #2;
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_req && rst_n) begin
        wait_cnt++;
        if (wait_cnt == 2) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            for (int b = 0; b < 64; b++) mem_view[mem_addr + 32'(b)] = mem_wdata[8*b +: 8];
          end else begin
            for (int b = 0; b < 64; b++) mem_rdata[8*b +: 8] = mem_byte(mem_addr + 32'(b));
          end
        end
      end
    end
  end

  // monitor: pops expected items as the design produces them
  int cyc = 0;
  int start_cyc = 0;
  int fill_cyc = -10;
  bit prev_valid = 0;
  always @(negedge clk) begin
    item_t it;
    if (rst_n) begin
      cyc++;
      if (cpu_valid && !prev_valid) start_cyc = cyc;
      prev_valid = cpu_valid;
      if (mem_req && mem_ack) begin
        if (sbq.size() == 0) begin
          check(0, "R6", "unexpected memory transfer", LINE_W'(mem_addr), '0);
        end else begin
          it = sbq.pop_front();
          if (mem_we) begin
            check(it.kind == K_WB, "R8", "write-back when none due (R6 clean victim)",
                  LINE_W'(mem_addr), LINE_W'(it.kind));
            check(mem_addr == it.addr, "R6", "write-back address", LINE_W'(mem_addr), LINE_W'(it.addr));
            check(mem_wdata == it.line, "R6", "write-back line", mem_wdata, it.line);
          end else begin
            check(it.kind == K_FILL, "R6", "refill issued where write-back due",
                  LINE_W'(mem_addr), LINE_W'(it.kind));
            check(mem_addr == it.addr, "R5", "refill of the line (R7 aligned)",
                  LINE_W'(mem_addr), LINE_W'(it.addr));
            fill_cyc = cyc;
          end
        end
      end
      if (cpu_valid && cpu_ready) begin
        if (sbq.size() == 0) begin
          check(0, "R2", "unexpected completion", LINE_W'(cpu_addr), '0);
        end else begin
          it = sbq.pop_front();
          check(it.kind == K_RESP, "R7", "completion before memory transfer",
                LINE_W'(cpu_addr), LINE_W'(it.kind));
          if (!it.is_write)
            check(cpu_rdata == it.rdata, "R3", "read data (R4 earlier stores)",
                  LINE_W'(cpu_rdata), LINE_W'(it.rdata));
          if (it.miss)
            check(cyc == fill_cyc + 1, "R7", "completion cycle after refill ack",
                  LINE_W'(cyc), LINE_W'(fill_cyc + 1));
          else
            check(cyc == start_cyc, "R2", "hit completion cycle",
                  LINE_W'(cyc), LINE_W'(start_cyc));
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=<100000", cyc);
    finish_run();
  end

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    rst_n = 1'b0;
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_size = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10: idle after reset
    check(cpu_ready == 1'b0, "R10", "ready after reset", LINE_W'(cpu_ready), '0);
    check(mem_req == 1'b0, "R10", "mem_req after reset", LINE_W'(mem_req), '0);

    // R10/R5/R7: first access misses and fills way 0
    access(0, 32'h0001_0000, 3'd4, '0);
    // R2/R3: hits with several sizes and unaligned offsets
    access(0, 32'h0001_0008, 3'd3, '0);
    access(0, 32'h0001_0007, 3'd2, '0);          // R3 rounds to offset 4
    access(0, 32'h0001_003F, 3'd0, '0);
    // R4/R8: narrow stores, then a full read of the same slot
    access(1, 32'h0001_0003, 3'd0, 128'hAB);
    access(1, 32'h0001_0005, 3'd2, 128'hFFFF_FFFF_1122_3344);  // R4 lands at offset 4
    access(1, 32'h0001_000A, 3'd1, 128'hBEEF);
    access(0, 32'h0001_0000, 3'd4, '0);
    // R5: second tag in set 0 goes to way 1, clean victim not written
    access(0, 32'h0002_0000, 3'd4, '0);
    // R5/R6: third tag evicts way 0, which is modified
    access(0, 32'h0003_0000, 3'd2, '0);
    access(0, 32'h0002_0010, 3'd3, '0);
    // R6/R8: next miss picks the clean way 1 line, no write-back
    access(0, 32'h0001_0000, 3'd4, '0);
    // R8: write miss marks the new line dirty; later eviction writes it back
    access(1, 32'h0004_0040, 3'd2, 128'hCAFE_F00D);
    access(0, 32'h0005_0040, 3'd2, '0);
    access(0, 32'h0006_0040, 3'd2, '0);
    access(0, 32'h0004_0040, 3'd4, '0);

    // mixed traffic over a few sets and tags
    for (int k = 0; k < 150; k++) begin
      logic [31:0] a;
      logic [2:0]  sz;
      logic [CPU_W-1:0] wd;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a[31:16] = 16'h0010 + 16'(seed[31:30]);
      a[15:12] = 4'h0;
      case (seed[29:28])
        2'd0: a[11:6] = 6'd0;
        2'd1: a[11:6] = 6'd1;
        2'd2: a[11:6] = 6'd5;
        default: a[11:6] = 6'd63;
      endcase
      a[5:0] = seed[27:22];
      sz = 3'(seed[21:19] % 5);
      wd = {seed, ~seed, seed ^ 32'h5A5A_5A5A, seed + 32'd7};
      access(seed[18], a, sz, wd);
    end

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R7", "expected transfers left over", LINE_W'(sbq.size()), '0);
    finish_run();
  end

endmodule